// File: doc/BRIEF.md
# Program/Erase Status Byte Generator

This block builds the byte a microcontroller reads to follow a program or erase job that an embedded algorithm is running on a flash sector, or a burst of one to 64 bytes written to an EEPROM page. The algorithm controller lives outside the block. It supplies, for each memory domain, a busy level. For flash it also supplies an error level and a level that stays high while further sector-erase commands are still accepted. The block captures the top bit of each byte written to a selected sector.

A read with any sector select high returns one status byte one cycle later. Bit 7 is a polling bit: while the job runs it reads as the complement of the last written byte's top bit, and it reads true once the job is done. Bit 6 flips on every status read while busy. Flash reads also report the error level in bit 5 and an erase time-out flag in bit 3. Bits that have no meaning read as zero. The status may be read any number of times. Flash and EEPROM keep their toggle and polling state apart.

Top module: `stsb_status_gen`

## Requirements
- R1: After reset `sts_vld` is 0 and `sts_data` is 0x00, both toggle bits are 0 and both captured top bits are 0.
- R2: A cycle with `rd_stb` high and at least one select high gives `sts_vld` high on the next cycle, with new `sts_data`. Any other cycle gives `sts_vld` low, leaves `sts_data` unchanged and leaves the toggle bits unchanged.
- R3: Bit 7 of a read equals the complement of that domain's captured top bit while that domain's busy input is high, and equals the captured bit itself when busy is low. A write (`wr_stb` with a select high) captures `wr_data[7]`. A read in the same cycle as a write still sees the earlier captured bit.
- R4: Bit 6 of a read returns the domain's current toggle bit. After a read made while that domain is busy, the toggle bit inverts, so back-to-back busy reads alternate.
- R5: A read made while the domain is not busy leaves its toggle bit unchanged, so repeated idle reads return the same bit 6.
- R6: On a flash read, bit 5 equals `fl_err`. Bit 3 is 1 when `fl_ers_open` is 0, and 0 while it is 1.
- R7: On an EEPROM read, bits 5 and 3 are 0 whatever the flash inputs are.
- R8: Bits 4, 2, 1 and 0 of every read are 0.
- R9: When a flash select and an EEPROM select are both high, reads and writes act on the flash domain only.
- R10: The flash and EEPROM domains keep separate toggle bits and captured top bits. Activity on one domain never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fl_sel | input | N_FL | Flash sector selects, active high |
| ee_sel | input | N_EE | EEPROM sector selects, active high |
| rd_stb | input | 1 | Status read strobe |
| wr_stb | input | 1 | Data write strobe |
| wr_data | input | 8 | Byte being written |
| fl_busy | input | 1 | Flash algorithm running |
| fl_err | input | 1 | Flash algorithm error |
| fl_ers_open | input | 1 | Flash erase command window still open |
| ee_busy | input | 1 | EEPROM write running |
| sts_vld | output | 1 | Status byte valid (one cycle after the read) |
| sts_data | output | 8 | Status byte |

## Verification
Directed sequences cover several cases. Runs of busy reads show that bit 6 alternates, and idle reads show that it holds. A busy-to-idle transition shows bit 7 moving from the complement to the true bit. Reads with both selects high tell flash priority apart from EEPROM handling, and reads with no select tell an ignored read apart from one that still moves the toggle. Constrained random cycles then mix reads, writes, select patterns and busy, error and window levels. Each bit field is compared with a bench model, which separates a fault in one field from a fault in the domain state. A follow-up read exposes any hidden change of state.

// File: rtl/stsb_pkg.sv
package stsb_pkg;
  localparam int unsigned DW = 8;

  // status byte bit positions (fixed by the reading software)
  localparam int unsigned BIT_POLL = 7;
  localparam int unsigned BIT_TGL  = 6;
  localparam int unsigned BIT_ERR  = 5;
  localparam int unsigned BIT_TMO  = 3;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_FLASH = 2'd1,
    SRC_EE    = 2'd2
  } src_e;
endpackage

// File: rtl/stsb_rst_sync.sv
module stsb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/stsb_sel_decode.sv
module stsb_sel_decode
  import stsb_pkg::*;
#(
  parameter int unsigned N_FL = 4,
  parameter int unsigned N_EE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_FL-1:0] fl_sel,
  input  logic [N_EE-1:0] ee_sel,
  input  logic            rd_stb,
  input  logic            wr_stb,
  output src_e            src,
  output logic            rd_any,
  output logic            rd_fl,
  output logic            rd_ee,
  output logic            wr_fl,
  output logic            wr_ee
);
  logic fl_any, ee_any;

  assign fl_any = |fl_sel;
  assign ee_any = |ee_sel;

  always_comb begin
    if (fl_any)      src = SRC_FLASH;
    else if (ee_any) src = SRC_EE;
    else             src = SRC_NONE;
  end

  assign rd_any = rd_stb && (src != SRC_NONE);
  assign rd_fl  = rd_stb && (src == SRC_FLASH);
  assign rd_ee  = rd_stb && (src == SRC_EE);
  assign wr_fl  = wr_stb && (src == SRC_FLASH);
  assign wr_ee  = wr_stb && (src == SRC_EE);

  // R9: a single domain is hit by any access
  assert_one_domain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_fl, rd_ee}) && $onehot0({wr_fl, wr_ee}));
  // R9: flash select wins over eeprom select
  assert_flash_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (|fl_sel)) |-> (rd_fl && !rd_ee));
endmodule

// File: rtl/stsb_track.sv
module stsb_track (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic wr_hit,
  input  logic wr_msb,
  input  logic rd_hit,
  output logic poll_bit,
  output logic tgl_bit
);
  logic msb_q, msb_n;
  logic tgl_q, tgl_n;
  logic msb_en, tgl_en;

  assign msb_en = wr_hit;
  assign tgl_en = rd_hit && busy;

  always_comb begin
    msb_n = msb_q;
    tgl_n = tgl_q;
    if (msb_en) msb_n = wr_msb;
    if (tgl_en) tgl_n = ~tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_q <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      msb_q <= msb_n;
      tgl_q <= tgl_n;
    end
  end

  assign poll_bit = busy ? ~msb_q : msb_q;
  assign tgl_bit  = tgl_q;

  // R4: a busy read flips the toggle bit
  assert_tgl_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && busy) |=> (tgl_bit != $past(tgl_bit)));
  // R5: no busy read, no change
  assert_tgl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_hit && busy) |=> $stable(tgl_bit));
  // R3: polling bit follows the captured byte once idle
  assert_poll_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !$isunknown(wr_msb)) ##1 (!busy && !wr_hit) |-> (poll_bit == $past(wr_msb)));
endmodule

// File: rtl/stsb_encode.sv
module stsb_encode
  import stsb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_any,
  input  src_e          src,
  input  logic          fl_poll,
  input  logic          fl_tgl,
  input  logic          fl_err,
  input  logic          fl_ers_open,
  input  logic          ee_poll,
  input  logic          ee_tgl,
  output logic          sts_vld,
  output logic [DW-1:0] sts_data
);
  logic [DW-1:0] byte_n, data_q, data_n;
  logic          vld_q, vld_n;

  always_comb begin
    byte_n = '0;
    unique case (src)
      SRC_FLASH: begin
        byte_n[BIT_POLL] = fl_poll;
        byte_n[BIT_TGL]  = fl_tgl;
        byte_n[BIT_ERR]  = fl_err;
        byte_n[BIT_TMO]  = ~fl_ers_open;
      end
      SRC_EE: begin
        byte_n[BIT_POLL] = ee_poll;
        byte_n[BIT_TGL]  = ee_tgl;
      end
      default: byte_n = '0;
    endcase
  end

  always_comb begin
    vld_n  = rd_any;
    data_n = rd_any ? byte_n : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_n;
      data_q <= data_n;
    end
  end

  assign sts_vld  = vld_q;
  assign sts_data = data_q;

  // R2: one cycle latency from a hitting read
  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> sts_vld);
  // R2: byte holds when nothing is read
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> (!sts_vld && $stable(sts_data)));
  // R8: meaningless bits stay low
  assert_undef_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_data[4] == 1'b0) && (sts_data[2:0] == 3'b000));
  // R7: eeprom reads carry no error or timeout bit
  assert_ee_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && src == SRC_EE) |=> (sts_data[BIT_ERR] == 1'b0 && sts_data[BIT_TMO] == 1'b0));
endmodule

// File: rtl/stsb_status_gen.sv
module stsb_status_gen
  import stsb_pkg::*;
#(
  parameter int unsigned N_FL = 4,
  parameter int unsigned N_EE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_FL-1:0] fl_sel,
  input  logic [N_EE-1:0] ee_sel,
  input  logic            rd_stb,
  input  logic            wr_stb,
  input  logic [7:0]      wr_data,
  input  logic            fl_busy,
  input  logic            fl_err,
  input  logic            fl_ers_open,
  input  logic            ee_busy,
  output logic            sts_vld,
  output logic [7:0]      sts_data
);
  logic rst_i_n;
  src_e src;
  logic rd_any, rd_fl, rd_ee, wr_fl, wr_ee;
  logic fl_poll, fl_tgl, ee_poll, ee_tgl;

  stsb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  stsb_sel_decode #(.N_FL(N_FL), .N_EE(N_EE)) u_dec (
    .clk(clk), .rst_n(rst_i_n), .fl_sel(fl_sel), .ee_sel(ee_sel),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .src(src), .rd_any(rd_any),
    .rd_fl(rd_fl), .rd_ee(rd_ee), .wr_fl(wr_fl), .wr_ee(wr_ee)
  );

  stsb_track u_fl_trk (
    .clk(clk), .rst_n(rst_i_n), .busy(fl_busy), .wr_hit(wr_fl),
    .wr_msb(wr_data[DW-1]), .rd_hit(rd_fl), .poll_bit(fl_poll), .tgl_bit(fl_tgl)
  );

  stsb_track u_ee_trk (
    .clk(clk), .rst_n(rst_i_n), .busy(ee_busy), .wr_hit(wr_ee),
    .wr_msb(wr_data[DW-1]), .rd_hit(rd_ee), .poll_bit(ee_poll), .tgl_bit(ee_tgl)
  );

  stsb_encode u_enc (
    .clk(clk), .rst_n(rst_i_n), .rd_any(rd_any), .src(src),
    .fl_poll(fl_poll), .fl_tgl(fl_tgl), .fl_err(fl_err), .fl_ers_open(fl_ers_open),
    .ee_poll(ee_poll), .ee_tgl(ee_tgl), .sts_vld(sts_vld), .sts_data(sts_data)
  );

  // R10: eeprom activity leaves flash toggle untouched
  assert_domain_iso_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_fl |=> $stable(fl_tgl));
endmodule

// File: tb/sim_stsb_status_gen.sv
`timescale 1ns/1ps
module sim_stsb_status_gen;
  localparam int NF = 4;
  localparam int NE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NF-1:0] fl_sel = '0;
  logic [NE-1:0] ee_sel = '0;
  logic rd_stb = 0, wr_stb = 0, fl_busy = 0, fl_err = 0, fl_ers_open = 0, ee_busy = 0;
  logic [7:0] wr_data = '0;
  logic sts_vld;
  logic [7:0] sts_data;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // bench model state
  bit m_fl_tgl, m_ee_tgl, m_fl_msb, m_ee_msb;
  logic [7:0] exp_data;
  bit exp_vld;

  always #2.5 clk = ~clk;

  stsb_status_gen #(.N_FL(NF), .N_EE(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .fl_sel(fl_sel), .ee_sel(ee_sel),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .fl_busy(fl_busy), .fl_err(fl_err), .fl_ers_open(fl_ers_open),
    .ee_busy(ee_busy), .sts_vld(sts_vld), .sts_data(sts_data)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_byte(bit is_fl, bit busy, bit msb, bit tgl, bit err, bit open);
    logic [7:0] b;
    b = '0;
    b[7] = busy ? ~msb : msb;
    b[6] = tgl;
    if (is_fl) begin
      b[5] = err;
      b[3] = ~open;
    end
    return b;
  endfunction

  // compute expectation for the upcoming edge from present inputs, update model
  task automatic predict();
    bit fa, ea, hf, he;
    fa = |fl_sel;
    ea = |ee_sel;
    hf = fa;
    he = !fa && ea;
    exp_vld = rd_stb && (fa || ea);
    if (rd_stb && hf) exp_data = model_byte(1, fl_busy, m_fl_msb, m_fl_tgl, fl_err, fl_ers_open);
    else if (rd_stb && he) exp_data = model_byte(0, ee_busy, m_ee_msb, m_ee_tgl, fl_err, fl_ers_open);
    if (rd_stb && hf && fl_busy) m_fl_tgl = !m_fl_tgl;
    if (rd_stb && he && ee_busy) m_ee_tgl = !m_ee_tgl;
    if (wr_stb && hf) m_fl_msb = wr_data[7];
    if (wr_stb && he) m_ee_msb = wr_data[7];
  endtask

  // one cycle: inputs are set, predict, clock, then compare at negedge
  task automatic cycle(string tag);
    predict();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R2 vld"}, {7'd0, sts_vld}, {7'd0, exp_vld});
    chk({tag, " R3 poll"}, {7'd0, sts_data[7]}, {7'd0, exp_data[7]});
    chk({tag, " R4 toggle"}, {7'd0, sts_data[6]}, {7'd0, exp_data[6]});
    chk({tag, " R6/R7 err+tmo"}, {6'd0, sts_data[5], sts_data[3]}, {6'd0, exp_data[5], exp_data[3]});
    chk({tag, " R8 undef"}, {4'd0, sts_data[4], sts_data[2:0]}, 8'd0);
  endtask

  task automatic idle();
    rd_stb = 0; wr_stb = 0; fl_sel = '0; ee_sel = '0;
  endtask

  task automatic rd_fl_t(); idle(); rd_stb = 1; fl_sel = 4'b0100; endtask
  task automatic rd_ee_t(); idle(); rd_stb = 1; ee_sel = 2'b01; endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    exp_data = '0; exp_vld = 0;
    m_fl_tgl = 0; m_ee_tgl = 0; m_fl_msb = 0; m_ee_msb = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset vld", {7'd0, sts_vld}, 8'd0);
    chk("R1 reset data", sts_data, 8'h00);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 post-release data", sts_data, 8'h00);

    // R1: first flash read, idle: toggle 0, captured bit 0, window closed -> tmo 1
    rd_fl_t(); cycle("R1 first read");
    chk("R1 first byte", sts_data, 8'h08);

    // R4: busy reads alternate; write 0x80 first
    idle(); wr_stb = 1; wr_data = 8'h80; fl_sel = 4'b0001; fl_busy = 1; fl_ers_open = 1; cycle("R3 wr");
    rd_fl_t(); cycle("R4 a");
    chk("R3 busy complement", {7'd0, sts_data[7]}, 8'd0);
    rd_fl_t(); cycle("R4 b");
    rd_fl_t(); cycle("R4 c");
    // R5: done, toggle holds across idle reads; R3 true bit
    fl_busy = 0;
    rd_fl_t(); cycle("R5 a");
    chk("R3 done true bit", {7'd0, sts_data[7]}, 8'd1);
    rd_fl_t(); cycle("R5 b");

    // R2: read with no select is ignored, then toggle seen unchanged
    fl_busy = 1;
    idle(); rd_stb = 1; cycle("R2 no sel");
    rd_fl_t(); cycle("R2 after ignored");

    // R7: eeprom read with flash error and closed window
    fl_err = 1; fl_ers_open = 0; ee_busy = 1;
    rd_ee_t(); cycle("R7 ee");
    // R9: both selects -> flash; R10: ee toggle unaffected
    idle(); rd_stb = 1; fl_sel = 4'b1000; ee_sel = 2'b10; cycle("R9 both");
    chk("R9 flash err bit", {7'd0, sts_data[5]}, 8'd1);
    rd_ee_t(); cycle("R10 ee after flash");
    // R3: write and read same cycle
    idle(); rd_stb = 1; wr_stb = 1; wr_data = 8'h7f; ee_sel = 2'b01; cycle("R3 same cycle");
    rd_ee_t(); cycle("R3 after write");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      idle();
      rd_stb = ($urandom_range(0, 3) != 0);
      wr_stb = ($urandom_range(0, 3) == 0);
      wr_data = 8'($urandom);
      case ($urandom_range(0, 5))
        0: ;
        1, 2: fl_sel = NF'($urandom_range(1, (1 << NF) - 1));
        3, 4: ee_sel = NE'($urandom_range(1, (1 << NE) - 1));
        default: begin
          fl_sel = NF'($urandom_range(1, (1 << NF) - 1));
          ee_sel = NE'($urandom_range(1, (1 << NE) - 1));
        end
      endcase
      if ($urandom_range(0, 15) == 0) fl_busy = !fl_busy;
      if ($urandom_range(0, 15) == 0) ee_busy = !ee_busy;
      fl_err = ($urandom_range(0, 7) == 0);
      fl_ers_open = $urandom_range(0, 1);
      cycle("R10 random");
    end

    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule